// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four reset requests into a single internal reset: power-on, an external active-low pin, brown-out and watchdog. Any active request sets the internal reset at once through an asynchronous path, so it works with no clock running. The external pin first passes through a synchronizer and a run-length counter, so short spikes on it are ignored.

Once every request has gone away, a two-stage synchronizer and a delay counter hold the internal reset for a programmable time. That time is chosen by a 2-bit start-up field and a 2-bit clock-select field. The reset then drops on a clock edge.

A sticky cause register records which sources caused resets. Software reads it from `status_o` and clears flags over a small write port, where a 0 in a bit position clears that flag. A power-on reset sets the power-on flag and wipes the other flags.

Top module: `rstc_top`

## Requirements
- R1: While power-on, watchdog, an enabled brown-out or a filtered pin request is active, `rst_o` is 1. For the first three sources this takes effect without any clock edge.
- R2: With a timeout of N clocks, `rst_o` falls on the (N+3)-th rising clock edge after the last asynchronous source goes inactive. The first edge after deassertion counts as edge 1.
- R3: N is a base value picked by `sut_i` (0: 0, 1: 16, 2: 512, 3: 4096) plus 4 times `cksel_i`.
- R4: The pin counts as a request only after it has been sampled low on 4 consecutive rising edges, so a pulse of 3 or fewer clock periods causes no reset. After a filtered pin reset, `rst_o` falls N+6 edges after the pin returns high.
- R5: A brown-out request is ignored when `bod_lvl_i` is 2'b11. With any other level value it asserts the reset.
- R6: If a source reasserts while the delay counter runs, the count starts over from zero once all sources are inactive again.
- R7: `status_o` bit 0 is power-on, bit 1 is pin, bit 2 is brown-out and bit 3 is watchdog. A flag is set 3 clock edges after its request is sampled. Bits 7:4 always read 0.
- R8: Power-on forces `status_o` to 8'h01 at once, clearing every other flag.
- R9: A write with `reg_wr_i` high clears each flag whose `reg_wdata_i` bit is 0 and leaves the rest. A write never sets a flag. An active source setting its flag wins over a clear in the same cycle. Without a write, flags never drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_req_i | input | 1 | Power-on reset request, active high |
| pin_n_i | input | 1 | External reset pin, active low, unfiltered |
| bod_req_i | input | 1 | Brown-out request, active high |
| bod_lvl_i | input | 2 | Brown-out level select; 2'b11 disables brown-out |
| wdt_req_i | input | 1 | Watchdog time-out request, active high |
| sut_i | input | 2 | Start-up time select (base timeout) |
| cksel_i | input | 2 | Clock-select field (extra margin) |
| reg_wr_i | input | 1 | Write strobe for the cause register |
| reg_wdata_i | input | 8 | Write data; 0 bits clear flags |
| rst_o | output | 1 | Internal reset, active high |
| status_o | output | 8 | Cause register read value |

## Verification
The hardest state to reach is a restart of the delay counter part-way through a release. The stimulus drops the watchdog request and lets the count run for ten cycles against a 16-clock timeout. It then raises the request again for a few cycles and checks that the full N+3 release time is counted from the second deassertion. The asynchronous path is reached by stopping the bench clock and raising a request while no edge occurs. The spike filter is probed at exactly one sample below and well above its threshold.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // Cause register layout; bit order is visible to software.
    typedef struct packed {
        logic [3:0] rsvd;   // never set, read as zero
        logic       wdt;    // bit 3
        logic       bod;    // bit 2
        logic       pin;    // bit 1
        logic       por;    // bit 0
    } cause_t;

    localparam logic [1:0] BOD_LVL_OFF = 2'b11;

    localparam cause_t CAUSE_POR_VAL = '{rsvd: 4'h0, wdt: 1'b0, bod: 1'b0, pin: 1'b0, por: 1'b1};

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int unsigned MIN_CLKS = 4
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic pin_n_i,
    output logic req_o
);
    localparam int unsigned CW = $clog2(MIN_CLKS + 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          req;
    } flt_t;

    logic low_s;
    flt_t st_d, st_q;

    rstc_sync #(.STAGES(2)) u_pin_sync (
        .clk_i (clk_i),
        .arst_i(arst_i),
        .d_i   (~pin_n_i),
        .q_o   (low_s)
    );

    always_comb begin
        st_d = st_q;
        if (!low_s) begin
            st_d.run = '0;
            st_d.req = 1'b0;
        end else begin
            if (st_q.run != CW'(MIN_CLKS)) st_d.run = st_q.run + 1'b1;
            st_d.req = (st_d.run == CW'(MIN_CLKS));
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/rstc_release.sv
module rstc_release #(
    parameter int unsigned TMO_W = 13
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             rst_o
);
    typedef struct packed {
        logic [1:0]       sy;
        logic [TMO_W-1:0] cnt;
        logic             rst;
    } rel_t;

    localparam rel_t REL_RST = '{sy: 2'b00, cnt: '0, rst: 1'b1};

    rel_t st_d, st_q;
    logic quiet, done;

    always_comb begin
        st_d    = st_q;
        quiet   = st_q.sy[1];
        done    = quiet && (st_q.cnt >= tmo_i);
        st_d.sy = {st_q.sy[0], 1'b1};
        if (quiet && !done) st_d.cnt = st_q.cnt + 1'b1;
        st_d.rst = !done;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= REL_RST;
        else        st_q <= st_d;
    end

    assign rst_o = st_q.rst;
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
(
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       pin_set_i,
    input  logic       bod_set_i,
    input  logic       wdt_set_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] flags_o
);
    cause_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (wr_i) fl_d = cause_t'(fl_q & wdata_i);
        if (pin_set_i) fl_d.pin = 1'b1;
        if (bod_set_i) fl_d.bod = 1'b1;
        if (wdt_set_i) fl_d.wdt = 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) fl_q <= CAUSE_POR_VAL;
        else       fl_q <= fl_d;
    end

    assign flags_o = fl_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned FILT_MIN   = 4,
    parameter int unsigned TMO_SUT0   = 0,
    parameter int unsigned TMO_SUT1   = 16,
    parameter int unsigned TMO_SUT2   = 512,
    parameter int unsigned TMO_SUT3   = 4096,
    parameter int unsigned CKSEL_STEP = 4
) (
    input  logic       clk_i,
    input  logic       por_req_i,
    input  logic       pin_n_i,
    input  logic       bod_req_i,
    input  logic [1:0] bod_lvl_i,
    input  logic       wdt_req_i,
    input  logic [1:0] sut_i,
    input  logic [1:0] cksel_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic       rst_o,
    output logic [7:0] status_o
);
    localparam int unsigned TMO_MAX = max4(TMO_SUT0, TMO_SUT1, TMO_SUT2, TMO_SUT3) + 3 * CKSEL_STEP;
    localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);
    localparam int unsigned N_SYNC  = 2;   // brown-out, watchdog

    logic             pin_req;
    logic             bod_act;
    logic             async_src;
    logic [TMO_W-1:0] tmo_base, tmo;
    logic [N_SYNC-1:0] raw_req, set_req;

    assign bod_act   = bod_req_i && (bod_lvl_i != BOD_LVL_OFF);
    assign async_src = por_req_i | pin_req | bod_act | wdt_req_i;

    always_comb begin
        case (sut_i)
            2'd0:    tmo_base = TMO_W'(TMO_SUT0);
            2'd1:    tmo_base = TMO_W'(TMO_SUT1);
            2'd2:    tmo_base = TMO_W'(TMO_SUT2);
            default: tmo_base = TMO_W'(TMO_SUT3);
        endcase
        tmo = tmo_base + TMO_W'(cksel_i) * TMO_W'(CKSEL_STEP);
    end

    rstc_pin_filter #(.MIN_CLKS(FILT_MIN)) u_pin (
        .clk_i  (clk_i),
        .arst_i (por_req_i),
        .pin_n_i(pin_n_i),
        .req_o  (pin_req)
    );

    assign raw_req = {wdt_req_i, bod_act};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_src_sync
        rstc_sync #(.STAGES(2)) u_sync (
            .clk_i (clk_i),
            .arst_i(por_req_i),
            .d_i   (raw_req[g]),
            .q_o   (set_req[g])
        );
    end

    rstc_release #(.TMO_W(TMO_W)) u_rel (
        .clk_i (clk_i),
        .arst_i(async_src),
        .tmo_i (tmo),
        .rst_o (rst_o)
    );

    rstc_cause u_cause (
        .clk_i    (clk_i),
        .por_i    (por_req_i),
        .pin_set_i(pin_req),
        .bod_set_i(set_req[0]),
        .wdt_set_i(set_req[1]),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .flags_o  (status_o)
    );
endmodule

// File: rtl/rstc_top_chk.sv
module rstc_top_chk (
    input logic       clk_i,
    input logic       por_req_i,
    input logic       bod_req_i,
    input logic [1:0] bod_lvl_i,
    input logic       wdt_req_i,
    input logic       reg_wr_i,
    input logic       rst_o,
    input logic [7:0] status_o
);
    logic bod_on;
    assign bod_on = bod_req_i && (bod_lvl_i != 2'b11);

    AST_SRC_HOLDS_RST: assert property (@(posedge clk_i) disable iff (por_req_i)
        (wdt_req_i || bod_on) |-> rst_o); // R1

    AST_RELEASE_QUIET: assert property (@(posedge clk_i) disable iff (por_req_i)
        $fell(rst_o) |-> (!wdt_req_i && !bod_on)); // R2

    AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (por_req_i)
        !reg_wr_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0]))); // R9

    AST_WDT_FLAGGED: assert property (@(posedge clk_i) disable iff (por_req_i)
        ($past(wdt_req_i, 3) && !$past(por_req_i, 1) && !$past(por_req_i, 2) && !$past(por_req_i, 3))
        |-> status_o[3]); // R7
endmodule

bind rstc_top rstc_top_chk u_chk (
    .clk_i    (clk_i),
    .por_req_i(por_req_i),
    .bod_req_i(bod_req_i),
    .bod_lvl_i(bod_lvl_i),
    .wdt_req_i(wdt_req_i),
    .reg_wr_i (reg_wr_i),
    .rst_o    (rst_o),
    .status_o (status_o)
);

// File: tb/rstc_top_tb.sv
`timescale 1ns/1ps
module rstc_top_tb;
    logic       clk = 1'b0;
    logic       clk_en = 1'b1;
    logic       por = 1'b1;
    logic       pin_n = 1'b1;
    logic       bod = 1'b0;
    logic [1:0] lvl = 2'b01;
    logic       wdt = 1'b0;
    logic [1:0] sut = 2'd0;
    logic [1:0] cksel = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rst;
    logic [7:0] status;

    int n_chk = 0;
    int n_fail = 0;

    always begin
        #5;
        if (clk_en) clk = ~clk;
    end

    rstc_top u_dut (
        .clk_i(clk), .por_req_i(por), .pin_n_i(pin_n), .bod_req_i(bod),
        .bod_lvl_i(lvl), .wdt_req_i(wdt), .sut_i(sut), .cksel_i(cksel),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .rst_o(rst), .status_o(status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Counts rising edges until rst is seen low; call right after deasserting at a negedge.
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk);
            n++;
            #1;
            if (!rst) break;
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic t_por();
        int n;
        repeat (3) @(negedge clk);
        check(rst == 1'b1, "R1", rst, 1);
        check(status == 8'h01, "R8", status, 8'h01);
        sut = 2'd0; cksel = 2'd0;
        por = 1'b0;
        measure(n);
        check(n == 3, "R2", n, 3);
    endtask

    task automatic t_async_noclk();
        int n;
        @(negedge clk);
        clk_en = 1'b0;
        #3 wdt = 1'b1;
        #1 check(rst == 1'b1, "R1", rst, 1);
        #2 clk_en = 1'b1;
        repeat (5) @(negedge clk);
        sut = 2'd1; cksel = 2'd2;
        wdt = 1'b0;
        measure(n);
        check(n == 27, "R3", n, 27);
        @(negedge clk);
        check(status == 8'h09, "R7", status, 8'h09);
    endtask

    task automatic t_timeout(input logic [1:0] s, input logic [1:0] c, input int exp);
        int n;
        @(negedge clk);
        sut = s; cksel = c;
        wdt = 1'b1;
        repeat (4) @(negedge clk);
        wdt = 1'b0;
        measure(n);
        check(n == exp + 3, "R3", n, exp + 3);
    endtask

    task automatic t_clear_all();
        wr_reg(8'h00);
        check(status == 8'h00, "R9", status, 8'h00);
        wr_reg(8'hFF);
        check(status == 8'h00, "R9", status, 8'h00);
    endtask

    task automatic t_bod();
        int n;
        bit stayed;
        @(negedge clk);
        sut = 2'd0; cksel = 2'd0; lvl = 2'b01;
        bod = 1'b1;
        #1 check(rst == 1'b1, "R5", rst, 1);
        repeat (5) @(negedge clk);
        bod = 1'b0;
        measure(n);
        check(n == 3, "R5", n, 3);
        @(negedge clk);
        check(status == 8'h04, "R7", status, 8'h04);
        lvl = 2'b11;
        bod = 1'b1;
        stayed = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (rst) stayed = 1'b0;
        end
        bod = 1'b0;
        check(stayed, "R5", !stayed, 0);
        repeat (3) @(negedge clk);
        check(status == 8'h04, "R5", status, 8'h04);
        lvl = 2'b01;
    endtask

    task automatic t_pin();
        int n;
        bit stayed;
        @(negedge clk);
        pin_n = 1'b0;
        repeat (3) @(negedge clk);
        pin_n = 1'b1;
        stayed = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (rst) stayed = 1'b0;
        end
        check(stayed, "R4", !stayed, 0);
        check(status == 8'h04, "R4", status, 8'h04);
        pin_n = 1'b0;
        repeat (8) @(negedge clk);
        check(rst == 1'b1, "R4", rst, 1);
        pin_n = 1'b1;
        measure(n);
        check(n == 6, "R4", n, 6);
        @(negedge clk);
        check(status == 8'h06, "R7", status, 8'h06);
    endtask

    task automatic t_partial_clear();
        wr_reg(8'hFB);
        check(status == 8'h02, "R9", status, 8'h02);
    endtask

    task automatic t_restart();
        int n;
        bit held;
        @(negedge clk);
        sut = 2'd1; cksel = 2'd0;
        wdt = 1'b1;
        repeat (4) @(negedge clk);
        wdt = 1'b0;
        held = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (!rst) held = 1'b0;
        end
        wdt = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (!rst) held = 1'b0;
        end
        wdt = 1'b0;
        check(held, "R6", !held, 0);
        measure(n);
        check(n == 19, "R6", n, 19);
    endtask

    task automatic t_set_wins();
        int n;
        wr_reg(8'h00);
        @(negedge clk);
        sut = 2'd0; cksel = 2'd0;
        wdt = 1'b1;
        repeat (4) @(negedge clk);
        wr_reg(8'h00);
        check(status == 8'h08, "R9", status, 8'h08);
        wdt = 1'b0;
        measure(n);
        check(n == 3, "R2", n, 3);
    endtask

    task automatic t_por_again();
        int n;
        @(negedge clk);
        check(status == 8'h08, "R8", status, 8'h08);
        #2 por = 1'b1;
        #1 check(status == 8'h01, "R8", status, 8'h01);
        check(rst == 1'b1, "R1", rst, 1);
        @(negedge clk);
        @(negedge clk);
        por = 1'b0;
        measure(n);
        check(n == 3, "R2", n, 3);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_por();
        t_async_noclk();
        t_timeout(2'd2, 2'd1, 516);
        t_timeout(2'd3, 2'd3, 4108);
        t_clear_all();
        t_bod();
        t_pin();
        t_partial_clear();
        t_restart();
        t_set_wins();
        t_por_again();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule